// File: doc/BRIEF.md
# TDM Audio Serial Receiver

This block turns one shared time-division-multiplexed serial data line into audio words. The bit clock and frame sync come from elsewhere (the same pair that drives the matching transmitter) and arrive as plain inputs sampled by the system clock. Every frame holds one to four slots of equal length, either 8 or 16 bits. A per-slot receive mask chooses the slots this device owns. Bits in any other slot, and bits that fall between the last configured slot and the next frame sync, are dropped.

Each owned slot has a route bit. The route bit sends its finished word either into a receive FIFO shared by all slots or into a holding register of the slot's own. The FIFO raises an interrupt while its fill level is above a programmable warning limit. A holding register raises a request while it holds an unread word. A word that finds its target full is lost and sets a sticky overrun flag. Single-slot operation is the case with a slot count of one and slot 0 owned.

The sequencer has four states. HUNT is the state after reset, where it waits for the first frame sync. CAPT means a slot is being shifted in. SKIP means a slot is being counted but not kept. TAIL means the frame's slots are over and it waits for the next sync. The transitions are named as follows:
- SYNC_START: from any state, on a frame-sync start, to CAPT or SKIP for slot 0.
- SLOT_NEXT: from CAPT or SKIP, at the end of a slot that is not the last, to CAPT or SKIP for the following slot.
- FRAME_END: from CAPT or SKIP, at the end of the last slot, to TAIL.
- HOLD: in every other case the state stays as it is.

Top module: `tdm_audio_rx`

## Requirements
- R1: After reset, `fifo_level` is 0 and `fifo_irq`, `hold_req` and `overrun` are all 0.
- R2: Bits sampled before the first frame-sync start are discarded. Until that start, nothing reaches the FIFO or the holding registers.
- R3: The data line and frame sync are sampled on each falling edge of `bclk`. A frame-sync start is a falling edge at which `fsync` is 1 after being 0 at the previous falling edge. The bit sampled at that same edge is the MSB of slot 0, and words arrive MSB first. A frame-sync start in the middle of a slot drops the partial word and restarts at slot 0.
- R4: `cfg_last` gives the index of the last slot in the frame (encoding 0..3 means 1..4 slots). Slots follow one another with no gap.
- R5: `cfg_wide`=1 selects 16-bit slots. `cfg_wide`=0 selects 8-bit slots, and the word is then placed in bits 7:0 with bits 15:8 set to zero.
- R6: A slot i is captured only when `cfg_mask[i]`=1. Otherwise it leaves no trace on any output.
- R7: A captured slot i goes to holding register i when `cfg_route[i]`=1 and to the FIFO when it is 0. FIFO words come out in the order they arrived.
- R8: `hold_req[i]` rises when holding register i is written. It clears in the cycle after a one-cycle pulse on `hold_rd[i]`. A read pulse on an empty register changes nothing.
- R9: `fifo_irq` is 1 exactly while `fifo_level` > `cfg_warn`.
- R10: A word is dropped when its target is full: the FIFO is full, or the holding register still has its request raised. In that case `overrun` sets and stays set until reset, and the stored contents do not change.
- R11: Bits after the last configured slot and before the next frame-sync start are ignored.
- R12: `fifo_data` always shows the oldest FIFO word. A `fifo_rd` pulse while the FIFO is not empty removes that word and lowers `fifo_level` by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock, sampled by clk |
| fsync | input | 1 | Frame sync |
| sdata | input | 1 | Serial receive data |
| cfg_last | input | 2 | Index of the last slot in a frame |
| cfg_wide | input | 1 | 1 = 16-bit slots, 0 = 8-bit slots |
| cfg_mask | input | 4 | Slot receive mask |
| cfg_route | input | 4 | Per slot: 1 = holding register, 0 = FIFO |
| cfg_warn | input | 4 | FIFO warning limit |
| fifo_rd | input | 1 | FIFO pop pulse |
| fifo_data | output | 16 | Oldest FIFO word |
| fifo_level | output | 4 | FIFO fill level |
| fifo_irq | output | 1 | Level above warning limit |
| hold_rd | input | 4 | Per-slot holding register read pulse |
| hold_data | output | 64 | Holding registers, slot i in bits 16i+15:16i |
| hold_req | output | 4 | Per-slot holding register full request |
| overrun | output | 1 | Sticky word-dropped flag |

## Verification
The assertions check several rules on every cycle. Nothing is delivered while the sequencer is still in HUNT, and every delivered word comes from a slot that is owned and inside the configured count. The FIFO level stays within its depth and moves by at most one per cycle. A request never falls without a read pulse, and the overrun flag never clears. Other behaviours only show up in the bench's scenarios, where the received words are compared with a model of the frame: the bit order, the 8-bit zero fill, the discarding of bits before the first sync and after the last slot, the restart on a sync in the middle of a slot, the routing, and the exact point at which words are dropped.

// File: rtl/tdmrx_pkg.sv
package tdmrx_pkg;

    // Sequencer states, see the brief for the transition names
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_CAPT = 2'd1,
        ST_SKIP = 2'd2,
        ST_TAIL = 2'd3
    } rx_state_e;

endpackage

// File: rtl/tdmrx_edge.sv
module tdmrx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    input  logic sdata,
    output logic bit_stb,
    output logic frame_go,
    output logic bit_val
);

    logic bclk_q;
    logic fs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            fs_q   <= 1'b0;
        end else begin
            bclk_q <= bclk;
            if (bit_stb) begin
                fs_q <= fsync;
            end
        end
    end

    // falling edge of the bit clock: the sampling instant
    assign bit_stb  = bclk_q & ~bclk;
    // sync seen high where it was low one bit earlier
    assign frame_go = bit_stb & fsync & ~fs_q;
    assign bit_val  = sdata;

endmodule

// File: rtl/tdmrx_seq.sv
module tdmrx_seq
    import tdmrx_pkg::*;
#(
    parameter int SLOTS    = 4,
    parameter int WORD_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_stb,
    input  logic                 frame_go,
    input  logic                 bit_val,
    input  logic [SW-1:0]        cfg_last,
    input  logic                 cfg_wide,
    input  logic [SLOTS-1:0]     cfg_mask,
    output logic                 word_vld,
    output logic [WORD_W-1:0]    word_data,
    output logic [SW-1:0]        word_slot,
    output rx_state_e            state
);

    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int BW = $clog2(WORD_W);

    rx_state_e             nxt;
    logic [BW-1:0]         bit_cnt;
    logic [SW-1:0]         slot_idx;
    logic [SW-1:0]         slot_nxt;
    logic [WORD_W-1:0]     shreg;
    logic [WORD_W-1:0]     sh_new;
    logic [BW-1:0]         last_bit;
    logic                  slot_end;
    logic                  in_slot;
    rx_state_e             first_st;
    rx_state_e             follow_st;

    assign last_bit  = cfg_wide ? BW'(WORD_W - 1) : BW'(NARROW_W - 1);
    assign in_slot   = (state == ST_CAPT) || (state == ST_SKIP);
    assign slot_end  = bit_stb && in_slot && (bit_cnt == last_bit);
    assign slot_nxt  = slot_idx + 1'b1;
    assign first_st  = cfg_mask[0] ? ST_CAPT : ST_SKIP;
    assign follow_st = cfg_mask[slot_nxt] ? ST_CAPT : ST_SKIP;

    // a new slot starts from an empty shift register
    assign sh_new = (frame_go || bit_cnt == '0)
                  ? {{(WORD_W-1){1'b0}}, bit_val}
                  : {shreg[WORD_W-2:0], bit_val};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HUNT;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT: begin
                if (frame_go) nxt = first_st;             // SYNC_START
            end
            ST_CAPT, ST_SKIP: begin
                if (frame_go) begin
                    nxt = first_st;                       // SYNC_START
                end else if (slot_end) begin
                    if (slot_idx == cfg_last) nxt = ST_TAIL;  // FRAME_END
                    else                      nxt = follow_st; // SLOT_NEXT
                end
            end
            ST_TAIL: begin
                if (frame_go) nxt = first_st;             // SYNC_START
            end
            default: nxt = ST_HUNT;
        endcase
    end

    // counters, shift register and word output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            slot_idx  <= '0;
            shreg     <= '0;
            word_vld  <= 1'b0;
            word_data <= '0;
            word_slot <= '0;
        end else begin
            word_vld <= 1'b0;
            if (frame_go) begin
                slot_idx <= '0;
                bit_cnt  <= BW'(1);
                shreg    <= sh_new;
            end else if (bit_stb && in_slot) begin
                shreg <= sh_new;
                if (slot_end) begin
                    bit_cnt  <= '0;
                    slot_idx <= slot_nxt;
                    if (state == ST_CAPT) begin
                        word_vld  <= 1'b1;
                        word_data <= sh_new;
                        word_slot <= slot_idx;
                    end
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tdmrx_fifo.sv
module tdmrx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic          full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;
    logic          do_push;
    logic          do_pop;

    assign full    = (level == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (level != '0);
    assign head    = mem[rptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

endmodule

// File: rtl/tdmrx_hold.sv
module tdmrx_hold #(
    parameter int SLOTS = 4,
    parameter int W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SLOTS-1:0]   wr,
    input  logic [W-1:0]       wr_data,
    input  logic [SLOTS-1:0]   rd,
    output logic [SLOTS*W-1:0] data,
    output logic [SLOTS-1:0]   full
);

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data[i*W +: W] <= '0;
                full[i]        <= 1'b0;
            end else if (wr[i]) begin
                data[i*W +: W] <= wr_data;
                full[i]        <= 1'b1;
            end else if (rd[i]) begin
                full[i]        <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tdm_audio_rx.sv
module tdm_audio_rx
    import tdmrx_pkg::*;
#(
    parameter int SLOTS      = 4,
    parameter int WORD_W     = 16,
    parameter int NARROW_W   = 8,
    parameter int FIFO_DEPTH = 8,
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bclk,
    input  logic                    fsync,
    input  logic                    sdata,
    input  logic [SW-1:0]           cfg_last,
    input  logic                    cfg_wide,
    input  logic [SLOTS-1:0]        cfg_mask,
    input  logic [SLOTS-1:0]        cfg_route,
    input  logic [LW-1:0]           cfg_warn,
    input  logic                    fifo_rd,
    output logic [WORD_W-1:0]       fifo_data,
    output logic [LW-1:0]           fifo_level,
    output logic                    fifo_irq,
    input  logic [SLOTS-1:0]        hold_rd,
    output logic [SLOTS*WORD_W-1:0] hold_data,
    output logic [SLOTS-1:0]        hold_req,
    output logic                    overrun
);

    logic              bit_stb;
    logic              frame_go;
    logic              bit_val;
    logic              word_vld;
    logic [WORD_W-1:0] word_data;
    logic [SW-1:0]     word_slot;
    rx_state_e         state;
    logic              fifo_full;
    logic              to_hold;
    logic              blocked;
    logic              fifo_push;
    logic [SLOTS-1:0]  hold_wr;

    tdmrx_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .fsync    (fsync),
        .sdata    (sdata),
        .bit_stb  (bit_stb),
        .frame_go (frame_go),
        .bit_val  (bit_val)
    );

    tdmrx_seq #(
        .SLOTS    (SLOTS),
        .WORD_W   (WORD_W),
        .NARROW_W (NARROW_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .frame_go  (frame_go),
        .bit_val   (bit_val),
        .cfg_last  (cfg_last),
        .cfg_wide  (cfg_wide),
        .cfg_mask  (cfg_mask),
        .word_vld  (word_vld),
        .word_data (word_data),
        .word_slot (word_slot),
        .state     (state)
    );

    // routing of a finished word and the drop decision
    assign to_hold   = cfg_route[word_slot];
    assign blocked   = to_hold ? hold_req[word_slot] : fifo_full;
    assign fifo_push = word_vld && !to_hold && !fifo_full;

    always_comb begin
        hold_wr = '0;
        if (word_vld && to_hold && !hold_req[word_slot]) begin
            hold_wr[word_slot] = 1'b1;
        end
    end

    tdmrx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (WORD_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (word_data),
        .pop       (fifo_rd),
        .head      (fifo_data),
        .level     (fifo_level),
        .full      (fifo_full)
    );

    tdmrx_hold #(
        .SLOTS (SLOTS),
        .W     (WORD_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (hold_wr),
        .wr_data (word_data),
        .rd      (hold_rd),
        .data    (hold_data),
        .full    (hold_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (word_vld && blocked) begin
            overrun <= 1'b1;
        end
    end

    assign fifo_irq = (fifo_level > cfg_warn);

endmodule

// File: rtl/tdmrx_chk.sv
module tdmrx_chk
    import tdmrx_pkg::*;
#(
    parameter int SLOTS      = 4,
    parameter int FIFO_DEPTH = 8,
    parameter int SW         = 2,
    parameter int LW         = 4
) (
    input logic             clk,
    input logic             rst_n,
    input rx_state_e        state,
    input logic             word_vld,
    input logic [SW-1:0]    word_slot,
    input logic [SW-1:0]    cfg_last,
    input logic [SLOTS-1:0] cfg_mask,
    input logic [LW-1:0]    fifo_level,
    input logic [SLOTS-1:0] hold_req,
    input logic [SLOTS-1:0] hold_rd,
    input logic             overrun
);

    // R2
    hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT) |-> (!word_vld && fifo_level == '0 && hold_req == '0));

    // R6
    owned_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> cfg_mask[word_slot]);

    // R4
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> (word_slot <= cfg_last));

    // R12
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_level) <= FIFO_DEPTH);

    // R12
    level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fifo_level) <= int'($past(fifo_level)) + 1) &&
        (int'(fifo_level) + 1 >= int'($past(fifo_level))));

    // R8
    req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(hold_req) & ~hold_req & ~$past(hold_rd)) == '0));

    // R10
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

bind tdm_audio_rx tdmrx_chk #(
    .SLOTS      (SLOTS),
    .FIFO_DEPTH (FIFO_DEPTH),
    .SW         (SW),
    .LW         (LW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .word_vld   (word_vld),
    .word_slot  (word_slot),
    .cfg_last   (cfg_last),
    .cfg_mask   (cfg_mask),
    .fifo_level (fifo_level),
    .hold_req   (hold_req),
    .hold_rd    (hold_rd),
    .overrun    (overrun)
);

// File: tb/sim_tdm_audio_rx.sv
`timescale 1ns/1ps
module sim_tdm_audio_rx;

    localparam int SLOTS = 4;
    localparam int W     = 16;
    localparam int DEPTH = 8;
    localparam int LW    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bclk = 1'b0;
    logic             fsync = 1'b0;
    logic             sdata = 1'b0;
    logic [1:0]       cfg_last = '0;
    logic             cfg_wide = 1'b0;
    logic [3:0]       cfg_mask = '0;
    logic [3:0]       cfg_route = '0;
    logic [LW-1:0]    cfg_warn = '0;
    logic             fifo_rd = 1'b0;
    logic [W-1:0]     fifo_data;
    logic [LW-1:0]    fifo_level;
    logic             fifo_irq;
    logic [3:0]       hold_rd = '0;
    logic [4*W-1:0]   hold_data;
    logic [3:0]       hold_req;
    logic             overrun;

    int total = 0;
    int bad   = 0;

    // bench model
    logic [15:0] mq [$];
    logic [15:0] mhold [4];
    logic [3:0]  mfull;
    logic        movr;
    logic [15:0] fw [4];

    always #4 clk = ~clk;

    tdm_audio_rx u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk       (bclk),
        .fsync      (fsync),
        .sdata      (sdata),
        .cfg_last   (cfg_last),
        .cfg_wide   (cfg_wide),
        .cfg_mask   (cfg_mask),
        .cfg_route  (cfg_route),
        .cfg_warn   (cfg_warn),
        .fifo_rd    (fifo_rd),
        .fifo_data  (fifo_data),
        .fifo_level (fifo_level),
        .fifo_irq   (fifo_irq),
        .hold_rd    (hold_rd),
        .hold_data  (hold_data),
        .hold_req   (hold_req),
        .overrun    (overrun)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] shape(input logic [15:0] w, input logic wide);
        return wide ? w : {8'h00, w[7:0]};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mq.delete();
        mfull = '0;
        movr  = 1'b0;
        for (int i = 0; i < 4; i++) mhold[i] = '0;
    endtask

    task automatic send_bit(input logic f, input logic d);
        @(negedge clk);
        bclk = 1'b1; fsync = f; sdata = d;
        @(negedge clk);
        @(negedge clk);
        bclk = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic model_put(input int s, input logic [15:0] w);
        if (cfg_route[s]) begin
            if (mfull[s]) movr = 1'b1;
            else begin mhold[s] = w; mfull[s] = 1'b1; end
        end else begin
            if (mq.size() == DEPTH) movr = 1'b1;
            else mq.push_back(w);
        end
    endtask

    // one full frame from fw[], then tail bits of random data
    task automatic send_frame(input int tail);
        int n;
        n = cfg_wide ? 16 : 8;
        for (int s = 0; s <= int'(cfg_last); s++) begin
            for (int b = n - 1; b >= 0; b--) begin
                send_bit((s == 0 && b == n - 1) ? 1'b1 : 1'b0, fw[s][b]);
            end
        end
        for (int t = 0; t < tail; t++) send_bit(1'b0, 1'($urandom));
        repeat (3) @(negedge clk);
        for (int s = 0; s <= int'(cfg_last); s++) begin
            if (cfg_mask[s]) model_put(s, shape(fw[s], cfg_wide));
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R12 level"}, 64'(fifo_level), 64'(mq.size()));
        chk({tag, " R9 irq"}, 64'(fifo_irq), 64'(mq.size() > int'(cfg_warn)));
        chk({tag, " R8 req"}, 64'(hold_req), 64'(mfull));
        chk({tag, " R10 overrun"}, 64'(overrun), 64'(movr));
        if (mq.size() > 0) chk({tag, " R7 head"}, 64'(fifo_data), 64'(mq[0]));
        for (int s = 0; s < 4; s++) begin
            if (mfull[s]) chk({tag, " R7 hold"}, 64'(hold_data[s*16 +: 16]), 64'(mhold[s]));
        end
    endtask

    task automatic pop_one(input string tag);
        if (mq.size() > 0) chk({tag, " R12 pop data"}, 64'(fifo_data), 64'(mq[0]));
        fifo_rd = 1'b1;
        @(negedge clk);
        fifo_rd = 1'b0;
        @(negedge clk);
        if (mq.size() > 0) void'(mq.pop_front());
    endtask

    task automatic read_hold(input int s);
        hold_rd[s] = 1'b1;
        @(negedge clk);
        hold_rd = '0;
        @(negedge clk);
        mfull[s] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1 reset state
        chk("R1 level", 64'(fifo_level), 0);
        chk("R1 irq", 64'(fifo_irq), 0);
        chk("R1 req", 64'(hold_req), 0);
        chk("R1 overrun", 64'(overrun), 0);

        // R2: bits before any frame sync
        cfg_last = 2'd0; cfg_wide = 1'b0; cfg_mask = 4'b0001; cfg_route = 4'b0000; cfg_warn = 4'd0;
        for (int i = 0; i < 20; i++) send_bit(1'b0, 1'($urandom));
        repeat (3) @(negedge clk);
        chk("R2 level before sync", 64'(fifo_level), 0);
        chk("R2 req before sync", 64'(hold_req), 0);

        // R3 R5: narrow slot, MSB first, zero upper byte
        fw[0] = 16'hABCD;
        send_frame(3);
        chk("R5 narrow word", 64'(fifo_data), 64'h00CD);
        check_all("R3");

        // R3: sync mid-slot drops the partial word
        send_bit(1'b1, 1'b1);
        for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b1);
        fw[0] = 16'h005A;
        send_frame(2);
        chk("R3 restart level", 64'(fifo_level), 2);
        check_all("R3 restart");
        while (mq.size() > 0) pop_one("R12");
        chk("R12 drained", 64'(fifo_level), 0);

        // R4 R6 R7 R11: four wide slots, slot 2 not owned, slot 1 to hold
        cfg_last = 2'd3; cfg_wide = 1'b1; cfg_mask = 4'b1011; cfg_route = 4'b0010; cfg_warn = 4'd1;
        fw[0] = 16'h1234; fw[1] = 16'hBEEF; fw[2] = 16'hDEAD; fw[3] = 16'h8001;
        send_frame(12);
        chk("R6 skipped slot level", 64'(fifo_level), 2);
        chk("R7 hold word", 64'(hold_data[31:16]), 64'hBEEF);
        check_all("R11");

        // R8: read clears, empty read changes nothing
        read_hold(1);
        chk("R8 cleared", 64'(hold_req), 0);
        read_hold(0);
        chk("R8 empty read", 64'(hold_req), 0);

        // R10: hold overrun
        send_frame(1);
        fw[1] = 16'h7777;
        send_frame(1);
        chk("R10 hold kept", 64'(hold_data[31:16]), 64'hBEEF);
        check_all("R10 hold");

        // R10: FIFO overflow
        cfg_mask = 4'b1111; cfg_route = 4'b0000;
        fw[0] = 16'hA0A0; fw[1] = 16'hB1B1; fw[2] = 16'hC2C2; fw[3] = 16'hD3D3;
        send_frame(0);
        chk("R10 fifo full", 64'(fifo_level), DEPTH);
        check_all("R10 fifo");
        while (mq.size() > 0) pop_one("R12");
        check_all("R12 empty");

        // random phase
        do_reset();
        check_all("R1 again");
        for (int f = 0; f < 60; f++) begin
            cfg_last  = 2'($urandom);
            cfg_wide  = 1'($urandom);
            cfg_mask  = 4'($urandom);
            cfg_route = 4'($urandom);
            cfg_warn  = 4'($urandom_range(0, 8));
            for (int s = 0; s < 4; s++) fw[s] = 16'($urandom);
            send_frame($urandom_range(0, 6));
            check_all("R7 random");
            for (int p = $urandom_range(0, 3); p > 0; p--) pop_one("R12 random");
            for (int s = 0; s < 4; s++) begin
                if ($urandom_range(0, 1) == 1) read_hold(s);
            end
            check_all("R9 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule